// File: doc/BRIEF.md
# Two-Stage Cascaded Watchdog

This block protects a system against hung software with two down-counters. Both counters advance only on a slow tick enable, nominally 10 kHz. Software first programs a 16-bit primary count and an 8-bit grace count. It then sets the enable bit. While the primary stage runs, the count can be refreshed ("kicked") in two ways. Software can write a strobe register at any time. An external kick pin can also do it, but only when hardware kicking is allowed.

If the primary stage runs out, the block raises an external warning pin. It then starts the grace stage, which cannot be kicked. Configuration bits can also request a one-cycle NMI pulse, an immediate reset, or both, at that moment. If the grace stage runs out, a reset is always issued. The only way to escape the grace stage is to clear the enable bit. Every reset pulse lasts a fixed number of clocks. Afterwards the block is disarmed and must be armed again by software.

Registers are written through a simple write port with a 2-bit address:

| Address | Meaning |
|---|---|
| 0 | Control register |
| 1 | Primary reload value |
| 2 | Grace reload value |
| 3 | Kick strobe |

The control bits are:

| Bit | Meaning |
|---|---|
| 0 | Enable |
| 1 | Allow pin kicks |
| 2 | NMI on primary expiry |
| 3 | Reset on primary expiry |

Top module: `cwdt_top`

## Requirements
- R1: After reset, `wdo_o`, `nmi_o` and `wd_rst_o` are low and the block is disarmed.
- R2: Writing the control register at address 0 with bit 0 set, while the enable bit is clear, loads both counters from their reload registers and arms the primary stage. With primary reload N, `wdo_o` goes high after the (N+1)th tick.
- R3: A write to address 3 reloads the primary counter while the primary stage runs, and it does so regardless of control bit 1.
- R4: A rising edge on `wdi_i`, passed through a two-flop synchronizer, reloads the primary counter only when control bit 1 is set. Otherwise it has no effect.
- R5: `wdo_o` rises at primary expiry and stays high until the block is disarmed or a reset pulse ends.
- R6: With control bit 2 set, primary expiry produces exactly one `nmi_o` pulse of one clock. With bit 2 clear, there is no pulse.
- R7: With control bit 3 set, primary expiry starts the reset pulse at once.
- R8: Without bit 3, primary expiry starts the grace stage, loaded with the grace reload value M. Reset starts after the (M+1)th tick. Kicks during the grace stage are ignored.
- R9: Writing the control register with bit 0 clear stops both stages, lowers `wdo_o`, and produces no reset.
- R10: `wd_rst_o` is high for exactly 16 clocks. Afterwards the enable bit is clear, `wdo_o` is low, ticks have no effect, and a new arm write starts a fresh primary stage.
- R11: A kick in the same cycle as the tick that would expire the primary stage wins, and no expiry occurs.
- R12: Counters change only on ticks. A reload value of 0 expires on the first tick after arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock count enable at the slow tick rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| wdi_i | input | 1 | Asynchronous external kick pin |
| wdo_o | output | 1 | Warning output, high after primary expiry |
| nmi_o | output | 1 | One-clock NMI request |
| wd_rst_o | output | 1 | Reset request pulse |

## Verification
A kick and the tick that would expire the primary stage can land in the same clock. The bench arms a primary count of 1 and spends one tick. It then drives the kick write and a tick on the same edge. The bench expects the primary stage to survive two more ticks before `wdo_o` rises, because the kick must win. A kick issued during the grace stage is checked the same way: the reset must still arrive on schedule.

// File: rtl/cwdt_pkg.sv
package cwdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STAGE1 = 2'd1,
        ST_STAGE2 = 2'd2,
        ST_RESET  = 2'd3
    } wd_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_RLD1 = 2'd1;
    localparam logic [1:0] ADDR_RLD2 = 2'd2;
    localparam logic [1:0] ADDR_KICK = 2'd3;

    localparam int CTRL_BITS = 4;

    // Field order follows control bit positions 3..0
    typedef struct packed {
        logic rst_sel;
        logic nmi_sel;
        logic hw_kick;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic arm;
        logic disarm;
        logic sw_kick;
    } cmd_t;

    function automatic logic is_running(input wd_state_t s);
        return (s == ST_STAGE1) || (s == ST_STAGE2);
    endfunction

endpackage

// File: rtl/cwdt_regs.sv
module cwdt_regs
    import cwdt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int S1_W   = 16,
    parameter int S2_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done_i,
    output ctrl_t             ctrl_o,
    output logic [S1_W-1:0]   rld1_o,
    output logic [S2_W-1:0]   rld2_o,
    output cmd_t              cmd_o
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_new;
    logic  wr_ctrl;

    assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
    assign ctrl_new = ctrl_t'(wr_data[CTRL_BITS-1:0]);

    always_comb begin
        cmd_o.arm     = wr_ctrl && ctrl_new.en && !ctrl_q.en;
        cmd_o.disarm  = wr_ctrl && !ctrl_new.en && ctrl_q.en;
        cmd_o.sw_kick = wr_en && (wr_addr == ADDR_KICK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rld1_o <= '0;
            rld2_o <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_new;
            if (wr_en && wr_addr == ADDR_RLD1)
                rld1_o <= wr_data[S1_W-1:0];
            if (wr_en && wr_addr == ADDR_RLD2)
                rld2_o <= wr_data[S2_W-1:0];
            // end of a reset pulse self-disarms, overriding a same-cycle write
            if (done_i)
                ctrl_q.en <= 1'b0;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/cwdt_sync_edge.sv
module cwdt_sync_edge #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    logic [DEPTH-1:0] chain_q;
    logic             last_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[DEPTH-1];
    end

    assign rise_o = chain_q[DEPTH-1] && !last_q;

endmodule

// File: rtl/cwdt_core.sv
module cwdt_core
    import cwdt_pkg::*;
#(
    parameter int S1_W      = 16,
    parameter int S2_W      = 8,
    parameter int PULSE_LEN = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  ctrl_t           ctrl_i,
    input  cmd_t            cmd_i,
    input  logic            pin_rise_i,
    input  logic [S1_W-1:0] rld1_i,
    input  logic [S2_W-1:0] rld2_i,
    output logic            wdo_o,
    output logic            nmi_o,
    output logic            rst_o,
    output logic            done_o,
    output wd_state_t       state_o
);
    localparam int PULSE_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PULSE_W-1:0] PULSE_LAST = PULSE_W'(PULSE_LEN - 1);

    wd_state_t         state_q;
    logic [S1_W-1:0]   cnt1_q;
    logic [S2_W-1:0]   cnt2_q;
    logic [PULSE_W-1:0] pulse_q;
    logic              kick;

    assign kick   = cmd_i.sw_kick || (ctrl_i.hw_kick && pin_rise_i);
    assign done_o = (state_q == ST_RESET) && (pulse_q == PULSE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt1_q  <= '0;
            cnt2_q  <= '0;
            pulse_q <= '0;
            wdo_o   <= 1'b0;
            nmi_o   <= 1'b0;
        end else begin
            nmi_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_i.arm) begin
                        cnt1_q  <= rld1_i;
                        cnt2_q  <= rld2_i;
                        state_q <= ST_STAGE1;
                    end
                end
                ST_STAGE1: begin
                    if (cmd_i.disarm) begin
                        state_q <= ST_IDLE;
                        wdo_o   <= 1'b0;
                    end else if (kick) begin
                        cnt1_q <= rld1_i;
                    end else if (tick_i) begin
                        if (cnt1_q == '0) begin
                            wdo_o   <= 1'b1;
                            nmi_o   <= ctrl_i.nmi_sel;
                            cnt2_q  <= rld2_i;
                            pulse_q <= '0;
                            state_q <= ctrl_i.rst_sel ? ST_RESET : ST_STAGE2;
                        end else begin
                            cnt1_q <= cnt1_q - 1'b1;
                        end
                    end
                end
                ST_STAGE2: begin
                    if (cmd_i.disarm) begin
                        state_q <= ST_IDLE;
                        wdo_o   <= 1'b0;
                    end else if (tick_i) begin
                        if (cnt2_q == '0) begin
                            pulse_q <= '0;
                            state_q <= ST_RESET;
                        end else begin
                            cnt2_q <= cnt2_q - 1'b1;
                        end
                    end
                end
                ST_RESET: begin
                    if (pulse_q == PULSE_LAST) begin
                        state_q <= ST_IDLE;
                        wdo_o   <= 1'b0;
                    end else begin
                        pulse_q <= pulse_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rst_o   = (state_q == ST_RESET);
    assign state_o = state_q;

endmodule

// File: rtl/cwdt_top.sv
module cwdt_top
    import cwdt_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int S1_W       = 16,
    parameter int S2_W       = 8,
    parameter int PULSE_LEN  = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wdi_i,
    output logic              wdo_o,
    output logic              nmi_o,
    output logic              wd_rst_o
);
    ctrl_t           ctrl;
    cmd_t            cmd;
    logic [S1_W-1:0] rld1;
    logic [S2_W-1:0] rld2;
    logic            pin_rise;
    logic            done;
    wd_state_t       core_state;

    cwdt_regs #(.DATA_W(DATA_W), .S1_W(S1_W), .S2_W(S2_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .done_i  (done),
        .ctrl_o  (ctrl),
        .rld1_o  (rld1),
        .rld2_o  (rld2),
        .cmd_o   (cmd)
    );

    cwdt_sync_edge #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (wdi_i),
        .rise_o (pin_rise)
    );

    cwdt_core #(.S1_W(S1_W), .S2_W(S2_W), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .ctrl_i     (ctrl),
        .cmd_i      (cmd),
        .pin_rise_i (pin_rise),
        .rld1_i     (rld1),
        .rld2_i     (rld2),
        .wdo_o      (wdo_o),
        .nmi_o      (nmi_o),
        .rst_o      (wd_rst_o),
        .done_o     (done),
        .state_o    (core_state)
    );

endmodule

// File: rtl/cwdt_checker.sv
module cwdt_checker
    import cwdt_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input logic      clk,
    input logic      rst,
    input logic      wdo,
    input logic      nmi,
    input logic      rst_out,
    input wd_state_t state,
    input logic      disarm,
    input logic      sw_kick
);
    localparam int RW = $clog2(PULSE_LEN + 1);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)          run_q <= '0;
        else if (rst_out) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    assert_pulse_bound_R10: assert property (@(posedge clk) disable iff (rst)
        rst_out |-> (run_q < RW'(PULSE_LEN)));

    assert_pulse_full_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> ($past(run_q) == RW'(PULSE_LEN - 1)));

    assert_wdo_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(wdo) |-> ($past(disarm) || $past(rst_out)));

    assert_nmi_at_expiry_R6: assert property (@(posedge clk) disable iff (rst)
        nmi |-> $rose(wdo));

    assert_nmi_single_R6: assert property (@(posedge clk) disable iff (rst)
        nmi |=> !nmi);

    assert_disarm_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (disarm && is_running(state)) |=> (state == ST_IDLE && !rst_out));

    assert_grace_no_kick_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STAGE2 && sw_kick) |=> (state != ST_STAGE1));

endmodule

bind cwdt_top cwdt_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wdo     (wdo_o),
    .nmi     (nmi_o),
    .rst_out (wd_rst_o),
    .state   (core_state),
    .disarm  (cmd.disarm),
    .sw_kick (cmd.sw_kick)
);

// File: tb/cwdt_top_tb.sv
module cwdt_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        wdi = 1'b0;
    logic        wdo, nmi, wd_rst;

    int n_tests = 0;
    int n_fail  = 0;
    int rst_seen = 0;
    int nmi_seen = 0;

    cwdt_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .wdi_i     (wdi),
        .wdo_o     (wdo),
        .nmi_o     (nmi),
        .wd_rst_o  (wd_rst)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst) begin
            if (wd_rst) rst_seen <= rst_seen + 1;
            if (nmi)    nmi_seen <= nmi_seen + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int r1, input int r2, input logic [15:0] ctl);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'(r1));
        wr(2'd2, 16'(r2));
        wr(2'd0, ctl);
    endtask

    task automatic pin_pulse();
        @(negedge clk); wdi = 1'b1;
        idle(4);
        wdi = 1'b0;
        idle(2);
    endtask

    task automatic t_reset();
        check("R1 wdo", wdo, 0);
        check("R1 nmi", nmi, 0);
        check("R1 rst", wd_rst, 0);
    endtask

    task automatic t_basic();
        int r0;
        r0 = rst_seen;
        setup(3, 200, 16'h0001);
        ticks(3);
        check("R2 before expiry", wdo, 0);
        ticks(1);
        check("R2 expiry", wdo, 1);
        idle(5);
        check("R5 wdo held", wdo, 1);
        wr(2'd0, 16'h0000);
        check("R9 wdo cleared", wdo, 0);
        ticks(4);
        check("R9 no reset", rst_seen - r0, 0);
    endtask

    task automatic t_zero();
        setup(0, 200, 16'h0001);
        idle(4);
        check("R12 no tick no count", wdo, 0);
        ticks(1);
        check("R12 zero reload", wdo, 1);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_sw_kick();
        setup(2, 200, 16'h0001);
        ticks(2);
        wr(2'd3, 16'h0000);
        ticks(2);
        check("R3 kick reloads", wdo, 0);
        ticks(1);
        check("R3 expiry after kick", wdo, 1);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_hw_kick();
        setup(3, 200, 16'h0001);
        ticks(3);
        pin_pulse();
        ticks(1);
        check("R4 pin ignored", wdo, 1);
        setup(3, 200, 16'h0003);
        ticks(3);
        pin_pulse();
        ticks(3);
        check("R4 pin kick", wdo, 0);
        ticks(1);
        check("R4 expiry after pin", wdo, 1);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_collide();
        setup(1, 200, 16'h0001);
        ticks(1);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd3;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        check("R11 kick wins", wdo, 0);
        ticks(1);
        check("R11 still counting", wdo, 0);
        ticks(1);
        check("R11 later expiry", wdo, 1);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_nmi();
        int n0, r0;
        n0 = nmi_seen; r0 = rst_seen;
        setup(0, 200, 16'h0005);
        ticks(1);
        idle(3);
        check("R6 one nmi pulse", nmi_seen - n0, 1);
        check("R6 no reset", rst_seen - r0, 0);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_rst_sel();
        int r0;
        r0 = rst_seen;
        setup(0, 200, 16'h0009);
        ticks(1);
        check("R7 immediate reset", wd_rst, 1);
        idle(20);
        check("R10 width", rst_seen - r0, 16);
        check("R10 wdo low", wdo, 0);
        ticks(3);
        check("R10 disarmed", rst_seen - r0, 16);
        check("R10 wdo stays low", wdo, 0);
        wr(2'd0, 16'h0001);
        ticks(1);
        check("R10 rearm", wdo, 1);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_stage2();
        int r0, n0;
        r0 = rst_seen; n0 = nmi_seen;
        setup(0, 2, 16'h0001);
        ticks(1);
        check("R8 wdo at expiry", wdo, 1);
        wr(2'd3, 16'h0000);
        ticks(2);
        check("R8 kick ignored", wd_rst, 0);
        ticks(1);
        check("R8 grace reset", wd_rst, 1);
        idle(20);
        check("R8 pulse width", rst_seen - r0, 16);
        check("R6 no nmi when off", nmi_seen - n0, 0);
    endtask

    task automatic t_disarm();
        int r0;
        r0 = rst_seen;
        setup(0, 3, 16'h0001);
        ticks(2);
        wr(2'd0, 16'h0000);
        check("R9 wdo off", wdo, 0);
        ticks(6);
        check("R9 grace stopped", rst_seen - r0, 0);
    endtask

    initial begin
        #4_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_basic();
        t_zero();
        t_sw_kick();
        t_hw_kick();
        t_collide();
        t_nmi();
        t_rst_sel();
        t_stage2();
        t_disarm();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule